// File: doc/BRIEF.md
# Termination Fault Monitor with Peak Capture

This block watches the two polarities of a serial output stage for a missing termination. On each measurement strobe it receives a 5-bit amplitude count per polarity. An unterminated line shows up as an amplitude that is too high, so the block compares each count against a 4-bit threshold and raises a per-polarity fault flag. The threshold is built from a 3-bit upper field and a separately held low bit. One of two such pairs is used, selected by the edge-rate mode input.

For diagnosis, each polarity keeps a live count and a running peak register. A 3-bit compare command resets both peaks and chooses between tracking the largest and tracking the smallest value. It can also switch either readback port from the live count to that polarity's peak. Detection runs only while the driver is enabled and a parameterised settling time has passed since enable. Outside that window, strobes are ignored and the flags are held low.

Two state machines make up the control. The arming machine has three states. It moves ARM_OFF to ARM_SETTLE when the driver is enabled, ARM_SETTLE to ARM_LIVE after SETTLE_CYC cycles, and from either ARM_SETTLE or ARM_LIVE back to ARM_OFF when the enable drops. The capture-mode machine has two states. The maximum-reset command moves it to CAP_MAX, and the minimum-reset command moves it to CAP_MIN. Every other command leaves it where it is.

Top module: `term_fault_mon`

## Requirements
- R1: While and after synchronous active-high reset, both fault flags and both readbacks are 0, the capture mode is maximum and both readbacks show the live count.
- R2: A strobe accepted while armed loads each polarity's live count from its amplitude input. An unselected readback shows that count from the cycle after the strobe.
- R3: On an accepted strobe each fault flag becomes 1 exactly when the amplitude, as an unsigned 5-bit value, exceeds the zero-extended threshold. The threshold is {sd_thr_hi, sd_thr_lsb} when rate_sd is 1 and {hd_thr_hi, hd_thr_lsb} when rate_sd is 0, with the 3-bit field as the upper bits.
- R4: A fault flag holds its value between accepted strobes and is cleared by the next accepted strobe whose amplitude no longer exceeds the threshold.
- R5: The block is armed only in cycles where drv_en is 1 and drv_en has been 1 on at least SETTLE_CYC previous clock edges in a row. While not armed, both flags are 0 from the next cycle, strobes are ignored, and live counts and peaks hold their values.
- R6: Command 3'b000 (with cmd_vld) resets both peaks to 0, selects maximum tracking and returns both readbacks to the live count.
- R7: Command 3'b001 switches the true-side readback to its peak, and command 3'b010 does the same for the complement side. The other side's selection is unaffected.
- R8: Command 3'b101 resets both peaks to 31, selects minimum tracking and returns both readbacks to the live count.
- R9: Commands 3'b011, 3'b100, 3'b110 and 3'b111 change no peak, mode or readback selection.
- R10: Every accepted strobe folds each amplitude into its peak: the larger of the two in maximum mode, the smaller in minimum mode. This happens whether or not the readback shows the peak.
- R11: When a peak-reset command and an accepted strobe fall in the same cycle, the peaks take the reset value and discard that sample. The live counts and fault flags are still updated from it.
- R12: With cmd_vld at 0 the cmd input has no effect.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| drv_en | input | 1 | Output driver enabled |
| rate_sd | input | 1 | Edge-rate mode: 1 selects the SD threshold, 0 the HD threshold |
| meas_stb | input | 1 | Measurement strobe |
| amp_true | input | 5 | Amplitude count, true polarity |
| amp_comp | input | 5 | Amplitude count, complement polarity |
| hd_thr_hi | input | 3 | HD threshold upper bits |
| hd_thr_lsb | input | 1 | HD threshold low bit |
| sd_thr_hi | input | 3 | SD threshold upper bits |
| sd_thr_lsb | input | 1 | SD threshold low bit |
| cmd_vld | input | 1 | Compare command valid |
| cmd | input | 3 | Compare command code |
| fault_true | output | 1 | Termination fault, true polarity |
| fault_comp | output | 1 | Termination fault, complement polarity |
| rb_true | output | 5 | Readback, true polarity (live or peak) |
| rb_comp | output | 5 | Readback, complement polarity (live or peak) |

## Verification
A peak-reset command and an accepted measurement strobe can land on the same clock edge. The bench provokes this by issuing the maximum-reset command in the same cycle as a strobe whose true-side amplitude is above threshold. It then judges the result in three ways. The live readbacks must carry the new sample, the true-side flag must rise, and after both peaks are selected they must read 0, showing that the sample was dropped from the peak. The threshold sweep covers every amplitude against every threshold in both rate modes, with the unused field pair driven to the complement value so that a wrong selection shows.

// File: rtl/tfm_pkg.sv
package tfm_pkg;

    typedef enum logic [1:0] {
        ARM_OFF    = 2'd0,
        ARM_SETTLE = 2'd1,
        ARM_LIVE   = 2'd2
    } arm_state_t;

    typedef enum logic {
        CAP_MAX = 1'b0,
        CAP_MIN = 1'b1
    } cap_mode_t;

    localparam logic [2:0] CMD_CLR_MAX = 3'b000;
    localparam logic [2:0] CMD_SEL_T   = 3'b001;
    localparam logic [2:0] CMD_SEL_C   = 3'b010;
    localparam logic [2:0] CMD_CLR_MIN = 3'b101;

endpackage

// File: rtl/tfm_arm_fsm.sv
module tfm_arm_fsm
    import tfm_pkg::*;
#(
    parameter int SETTLE_CYC = 1000000
) (
    input  logic clk,
    input  logic rst,
    input  logic drv_en,
    output logic live_ok
);
    localparam int SW = $clog2(SETTLE_CYC + 1);
    localparam logic [SW-1:0] LAST = SW'(SETTLE_CYC - 1);

    arm_state_t      state_q, state_d;
    logic [SW-1:0]   wait_q;

    always_ff @(posedge clk) begin
        if (rst) state_q <= ARM_OFF;
        else     state_q <= state_d;
    end

    always_comb begin
        state_d = state_q;
        unique case (state_q)
            ARM_OFF:    if (drv_en) state_d = ARM_SETTLE;
            ARM_SETTLE: begin
                if (!drv_en)            state_d = ARM_OFF;
                else if (wait_q == LAST) state_d = ARM_LIVE;
            end
            ARM_LIVE:   if (!drv_en) state_d = ARM_OFF;
            default:    state_d = ARM_OFF;
        endcase
    end

    always_ff @(posedge clk) begin
        if (rst || state_q != ARM_SETTLE || !drv_en) wait_q <= '0;
        else if (wait_q != LAST)                     wait_q <= wait_q + 1'b1;
    end

    always_comb begin
        live_ok = (state_q == ARM_LIVE) && drv_en;
    end

    AST_OFF_WHEN_LOW: assert property (@(posedge clk) disable iff (rst)
        !drv_en |=> state_q == ARM_OFF); // R5
    AST_NO_SKIP_SETTLE: assert property (@(posedge clk) disable iff (rst)
        (state_q == ARM_OFF) |=> state_q != ARM_LIVE); // R5

endmodule

// File: rtl/tfm_cmd_ctrl.sv
module tfm_cmd_ctrl
    import tfm_pkg::*;
#(
    parameter int CNT_W     = 5,
    parameter int NUM_LANES = 2
) (
    input  logic                 clk,
    input  logic                 rst,
    input  logic                 cmd_vld,
    input  logic [2:0]           cmd,
    output logic                 max_mode,
    output logic [NUM_LANES-1:0] cap_sel,
    output logic                 peak_clr,
    output logic [CNT_W-1:0]     peak_clr_val
);
    cap_mode_t mode_q, mode_d;
    logic      go_max, go_min, rsvd;

    always_comb begin
        go_max = cmd_vld && (cmd == CMD_CLR_MAX);
        go_min = cmd_vld && (cmd == CMD_CLR_MIN);
        rsvd   = cmd_vld && !(cmd == CMD_CLR_MAX || cmd == CMD_CLR_MIN ||
                              cmd == CMD_SEL_T   || cmd == CMD_SEL_C);
    end

    always_ff @(posedge clk) begin
        if (rst) mode_q <= CAP_MAX;
        else     mode_q <= mode_d;
    end

    always_comb begin
        mode_d = mode_q;
        unique case (mode_q)
            CAP_MAX: if (go_min) mode_d = CAP_MIN;
            CAP_MIN: if (go_max) mode_d = CAP_MAX;
            default: mode_d = CAP_MAX;
        endcase
    end

    always_comb begin
        max_mode     = (mode_q == CAP_MAX);
        peak_clr     = go_max || go_min;
        peak_clr_val = go_min ? {CNT_W{1'b1}} : '0;
    end

    for (genvar i = 0; i < NUM_LANES; i++) begin : g_sel
        localparam logic [2:0] MY_CODE = 3'(1 << i);
        always_ff @(posedge clk) begin
            if (rst || go_max || go_min)     cap_sel[i] <= 1'b0;
            else if (cmd_vld && cmd == MY_CODE) cap_sel[i] <= 1'b1;
        end
    end

    AST_RSVD_KEEP: assert property (@(posedge clk) disable iff (rst)
        rsvd |=> ($stable(cap_sel) && $stable(mode_q))); // R9
    AST_IDLE_KEEP: assert property (@(posedge clk) disable iff (rst)
        !cmd_vld |=> ($stable(cap_sel) && $stable(mode_q))); // R12
    AST_CLR_DESELECT: assert property (@(posedge clk) disable iff (rst)
        peak_clr |=> cap_sel == '0); // R6

endmodule

// File: rtl/tfm_lane.sv
module tfm_lane #(
    parameter int CNT_W = 5,
    parameter int THR_W = 4
) (
    input  logic             clk,
    input  logic             rst,
    input  logic             live_ok,
    input  logic             stb,
    input  logic [CNT_W-1:0] amp,
    input  logic [THR_W-1:0] thr,
    input  logic             max_mode,
    input  logic             cap_sel,
    input  logic             peak_clr,
    input  logic [CNT_W-1:0] peak_clr_val,
    output logic             fault,
    output logic [CNT_W-1:0] rb
);
    logic             accept;
    logic [CNT_W-1:0] cnt_q, peak_q, folded;
    logic [CNT_W-1:0] thr_ext;

    always_comb begin
        accept  = live_ok && stb;
        thr_ext = CNT_W'(thr);
        if (max_mode) folded = (amp > peak_q) ? amp : peak_q;
        else          folded = (amp < peak_q) ? amp : peak_q;
    end

    always_ff @(posedge clk) begin
        if (rst)         cnt_q <= '0;
        else if (accept) cnt_q <= amp;
    end

    always_ff @(posedge clk) begin
        if (rst)           peak_q <= '0;
        else if (peak_clr) peak_q <= peak_clr_val;
        else if (accept)   peak_q <= folded;
    end

    always_ff @(posedge clk) begin
        if (rst || !live_ok) fault <= 1'b0;
        else if (accept)     fault <= (amp > thr_ext);
    end

    always_comb begin
        rb = cap_sel ? peak_q : cnt_q;
    end

    AST_FAULT_QUIET: assert property (@(posedge clk) disable iff (rst)
        !live_ok |=> !fault); // R5
    AST_CNT_HOLD: assert property (@(posedge clk) disable iff (rst)
        !accept |=> $stable(cnt_q)); // R5
    AST_PEAK_MAX: assert property (@(posedge clk) disable iff (rst)
        (accept && !peak_clr && max_mode) |=> peak_q >= $past(amp)); // R10
    AST_PEAK_MIN: assert property (@(posedge clk) disable iff (rst)
        (accept && !peak_clr && !max_mode) |=> peak_q <= $past(amp)); // R10
    AST_CLR_WINS: assert property (@(posedge clk) disable iff (rst)
        peak_clr |=> peak_q == $past(peak_clr_val)); // R11

endmodule

// File: rtl/term_fault_mon.sv
module term_fault_mon #(
    parameter int CNT_W      = 5,
    parameter int THR_HI_W   = 3,
    parameter int SETTLE_CYC = 1000000
) (
    input  logic                clk,
    input  logic                rst,
    input  logic                drv_en,
    input  logic                rate_sd,
    input  logic                meas_stb,
    input  logic [CNT_W-1:0]    amp_true,
    input  logic [CNT_W-1:0]    amp_comp,
    input  logic [THR_HI_W-1:0] hd_thr_hi,
    input  logic                hd_thr_lsb,
    input  logic [THR_HI_W-1:0] sd_thr_hi,
    input  logic                sd_thr_lsb,
    input  logic                cmd_vld,
    input  logic [2:0]          cmd,
    output logic                fault_true,
    output logic                fault_comp,
    output logic [CNT_W-1:0]    rb_true,
    output logic [CNT_W-1:0]    rb_comp
);
    localparam int THR_W     = THR_HI_W + 1;
    localparam int NUM_LANES = 2;

    logic                 live_ok;
    logic                 max_mode;
    logic [NUM_LANES-1:0] cap_sel;
    logic                 peak_clr;
    logic [CNT_W-1:0]     peak_clr_val;
    logic [THR_W-1:0]     thr;
    logic [CNT_W-1:0]     amp_a   [NUM_LANES];
    logic [CNT_W-1:0]     rb_a    [NUM_LANES];
    logic                 fault_a [NUM_LANES];

    always_comb begin
        thr      = rate_sd ? {sd_thr_hi, sd_thr_lsb} : {hd_thr_hi, hd_thr_lsb};
        amp_a[0] = amp_true;
        amp_a[1] = amp_comp;
    end

    tfm_arm_fsm #(.SETTLE_CYC(SETTLE_CYC)) u_arm (
        .clk     (clk),
        .rst     (rst),
        .drv_en  (drv_en),
        .live_ok (live_ok)
    );

    tfm_cmd_ctrl #(.CNT_W(CNT_W), .NUM_LANES(NUM_LANES)) u_cmd (
        .clk          (clk),
        .rst          (rst),
        .cmd_vld      (cmd_vld),
        .cmd          (cmd),
        .max_mode     (max_mode),
        .cap_sel      (cap_sel),
        .peak_clr     (peak_clr),
        .peak_clr_val (peak_clr_val)
    );

    for (genvar i = 0; i < NUM_LANES; i++) begin : g_lane
        tfm_lane #(.CNT_W(CNT_W), .THR_W(THR_W)) u_lane (
            .clk          (clk),
            .rst          (rst),
            .live_ok      (live_ok),
            .stb          (meas_stb),
            .amp          (amp_a[i]),
            .thr          (thr),
            .max_mode     (max_mode),
            .cap_sel      (cap_sel[i]),
            .peak_clr     (peak_clr),
            .peak_clr_val (peak_clr_val),
            .fault        (fault_a[i]),
            .rb           (rb_a[i])
        );
    end

    always_comb begin
        fault_true = fault_a[0];
        fault_comp = fault_a[1];
        rb_true    = rb_a[0];
        rb_comp    = rb_a[1];
    end

    AST_FLAG_NEEDS_EN: assert property (@(posedge clk) disable iff (rst)
        (fault_true || fault_comp) |-> $past(drv_en)); // R5
    AST_FAULT_ABOVE: assert property (@(posedge clk) disable iff (rst)
        (live_ok && meas_stb && amp_true > CNT_W'(thr)) |=> fault_true); // R3

endmodule

// File: tb/tb_term_fault_mon.sv
module tb_term_fault_mon;
    localparam int S = 6;

    logic       clk = 1'b0;
    logic       rst = 1'b1;
    logic       drv_en = 1'b0;
    logic       rate_sd = 1'b0;
    logic       meas_stb = 1'b0;
    logic [4:0] amp_true = '0, amp_comp = '0;
    logic [2:0] hd_thr_hi = 3'b100, sd_thr_hi = 3'b010;
    logic       hd_thr_lsb = 1'b1, sd_thr_lsb = 1'b1;
    logic       cmd_vld = 1'b0;
    logic [2:0] cmd = '0;
    logic       fault_true, fault_comp;
    logic [4:0] rb_true, rb_comp;

    int ntot = 0;
    int nbad = 0;
    bit done = 1'b0;

    always #2 clk = ~clk;

    term_fault_mon #(.CNT_W(5), .THR_HI_W(3), .SETTLE_CYC(S)) dut (
        .clk(clk), .rst(rst), .drv_en(drv_en), .rate_sd(rate_sd),
        .meas_stb(meas_stb), .amp_true(amp_true), .amp_comp(amp_comp),
        .hd_thr_hi(hd_thr_hi), .hd_thr_lsb(hd_thr_lsb),
        .sd_thr_hi(sd_thr_hi), .sd_thr_lsb(sd_thr_lsb),
        .cmd_vld(cmd_vld), .cmd(cmd),
        .fault_true(fault_true), .fault_comp(fault_comp),
        .rb_true(rb_true), .rb_comp(rb_comp)
    );

    task automatic chk(input int act, input int exp, input string tag);
        ntot++;
        if (act != exp) begin
            nbad++;
            $display("FAIL %s actual=%0d expected=%0d", tag, act, exp);
        end
    endtask

    // drive one cycle at the negedge, sample at the following negedge
    task automatic step(input logic s, input logic [4:0] at, input logic [4:0] ac,
                        input logic cv, input logic [2:0] c);
        meas_stb = s; amp_true = at; amp_comp = ac; cmd_vld = cv; cmd = c;
        @(posedge clk);
        @(negedge clk);
        meas_stb = 1'b0; cmd_vld = 1'b0;
    endtask

    task automatic strobe(input logic [4:0] at, input logic [4:0] ac);
        step(1'b1, at, ac, 1'b0, 3'b000);
    endtask

    task automatic command(input logic [2:0] c);
        step(1'b0, 5'd0, 5'd0, 1'b1, c);
    endtask

    initial begin
        repeat (200000) @(posedge clk);
        if (!done) begin
            nbad++;
            ntot++;
            $display("FAIL watchdog actual=hung expected=finished");
            $display("  test done: total=%0d bad=%0d", ntot, nbad);
            $finish;
        end
    end

    initial begin
        repeat (3) @(posedge clk);
        @(negedge clk);
        chk(fault_true, 0, "R1 fault_true in reset");
        chk(rb_true, 0, "R1 rb_true in reset");
        rst = 1'b0;
        @(negedge clk);
        chk(fault_comp, 0, "R1 fault_comp after reset");
        chk(rb_comp, 0, "R1 rb_comp after reset");

        // settle window: strobes ignored, flags low
        drv_en = 1'b1;
        hd_thr_hi = 3'b000; hd_thr_lsb = 1'b0;
        for (int k = 0; k < S; k++) strobe(5'd20, 5'd21);
        chk(rb_true, 0, "R5 strobe ignored while settling");
        chk(rb_comp, 0, "R5 strobe ignored while settling comp");
        chk(fault_true, 0, "R5 flag low while settling");
        step(1'b0, 5'd0, 5'd0, 1'b0, 3'b000);
        step(1'b0, 5'd0, 5'd0, 1'b0, 3'b000);

        // exhaustive threshold sweep, both rate modes
        for (int r = 0; r < 2; r++) begin
            for (int t = 0; t < 16; t++) begin
                logic [3:0] tv;
                tv = 4'(t);
                rate_sd = r[0];
                if (r == 1) begin
                    sd_thr_hi = tv[3:1]; sd_thr_lsb = tv[0];
                    hd_thr_hi = ~tv[3:1]; hd_thr_lsb = ~tv[0];
                end else begin
                    hd_thr_hi = tv[3:1]; hd_thr_lsb = tv[0];
                    sd_thr_hi = ~tv[3:1]; sd_thr_lsb = ~tv[0];
                end
                for (int a = 0; a < 32; a++) begin
                    strobe(5'(a), 5'(31 - a));
                    chk(fault_true, (a > t) ? 1 : 0, "R3 fault_true sweep");
                    chk(fault_comp, ((31 - a) > t) ? 1 : 0, "R4 fault_comp falling sweep");
                    chk(rb_true, a, "R2 live readback");
                end
            end
        end
        step(1'b0, 5'd0, 5'd0, 1'b0, 3'b000);
        chk(fault_true, 1, "R4 flag held between strobes");
        chk(rb_comp, 0, "R2 live comp after sweep");

        command(3'b001);
        chk(rb_true, 31, "R7 true peak selected");
        chk(rb_comp, 0, "R7 comp stays live");
        command(3'b010);
        chk(rb_comp, 31, "R7 comp peak selected");

        rate_sd = 1'b0; hd_thr_hi = 3'b100; hd_thr_lsb = 1'b1;
        command(3'b000);
        chk(rb_true, 31, "R6 true back to live");
        chk(rb_comp, 0, "R6 comp back to live");
        strobe(5'd5, 5'd9);
        strobe(5'd12, 5'd3);
        command(3'b001);
        command(3'b010);
        chk(rb_true, 12, "R10 max peak true");
        chk(rb_comp, 9, "R10 max peak comp");

        command(3'b011); chk(rb_true, 12, "R9 code 011 no effect");
        command(3'b100); chk(rb_comp, 9, "R9 code 100 no effect");
        command(3'b110); chk(rb_true, 12, "R9 code 110 no effect");
        command(3'b111); chk(rb_comp, 9, "R9 code 111 no effect");
        step(1'b0, 5'd0, 5'd0, 1'b0, 3'b000);
        chk(rb_true, 12, "R12 cmd without valid ignored");
        chk(rb_comp, 9, "R12 cmd without valid ignored comp");

        command(3'b101);
        chk(rb_true, 12, "R8 true live after min reset");
        chk(rb_comp, 3, "R8 comp live after min reset");
        command(3'b001);
        command(3'b010);
        chk(rb_true, 31, "R8 peak reset to 31");
        chk(rb_comp, 31, "R8 comp peak reset to 31");
        strobe(5'd7, 5'd20);
        strobe(5'd4, 5'd25);
        chk(rb_true, 4, "R10 min peak true");
        chk(rb_comp, 20, "R10 min peak comp");

        // peak reset and accepted strobe on the same edge
        step(1'b1, 5'd17, 5'd2, 1'b1, 3'b000);
        chk(rb_true, 17, "R11 live count loads on reset edge");
        chk(rb_comp, 2, "R11 live comp loads on reset edge");
        chk(fault_true, 1, "R11 fault evaluated on reset edge");
        chk(fault_comp, 0, "R11 comp fault evaluated");
        command(3'b001);
        command(3'b010);
        chk(rb_true, 0, "R11 sample dropped from peak");
        chk(rb_comp, 0, "R11 sample dropped from comp peak");

        // disable: flags drop, strobes ignored
        drv_en = 1'b0;
        step(1'b0, 5'd0, 5'd0, 1'b0, 3'b000);
        chk(fault_true, 0, "R5 flag cleared on disable");
        strobe(5'd30, 5'd30);
        command(3'b000);
        chk(rb_true, 17, "R5 count held while disabled");
        chk(rb_comp, 2, "R5 comp count held while disabled");

        drv_en = 1'b1;
        strobe(5'd30, 5'd30);
        chk(rb_true, 17, "R5 strobe ignored after re-enable");
        chk(fault_true, 0, "R5 flag low after re-enable");
        repeat (S + 1) step(1'b0, 5'd0, 5'd0, 1'b0, 3'b000);
        strobe(5'd30, 5'd1);
        chk(rb_true, 30, "R2 live after re-arm");
        chk(fault_true, 1, "R3 fault after re-arm");
        chk(fault_comp, 0, "R3 comp no fault after re-arm");

        done = 1'b1;
        $display("  test done: total=%0d bad=%0d", ntot, nbad);
        $finish;
    end
endmodule